// File: doc/BRIEF.md
# Time-to-Digital Measurement Controller

This block measures the time between an activity on a start line and an activity on a stop line by counting edges of its own clock. Both clock edges are counted, so every clock cycle inside the window adds two to a 25-bit result. The start and stop lines arrive already selected from their sources. A two-stage synchronizer samples each line, and a polarity bit per line chooses whether a high or a low level counts as active.

Software drives the block with a 2-bit command strobe that can clear the results, start a run, or abort a run. One run mode counts as soon as the start line is active. The other mode first waits for the start line to go inactive and then counts from the next time it becomes active, so the window always begins on a real edge. A stop counter can be enabled so that the run ends on the N-th stop edge, which lets one run cover several periods of a signal. A selectable saturation bit ends a run that has no stop. An encoded state field shows where the sequencer is.

Top module: `tdc_ctrl`

## Requirements
- R1: After reset, state_code is 0x06 (idle), result is 0, and done and sat are 0.
- R2: In a level-started run (cmd 2) with the stop counter off, result equals twice the number of clock cycles between the start line becoming active and the stop line becoming active. Both lines pass through the same two-flop synchronizer. When the run ends, done is 1 and state_code returns to 0x06.
- R3: In a level-started run, a start line that is already active when the command arrives starts counting without waiting for an edge.
- R4: In an edge-started run (cmd 1), the controller stays in state 0x1E with result 0 until the start line goes from active to inactive. It then waits in state 0x00 and counts from the next time start becomes active, and result is measured from that point as in R2.
- R5: When start_pol is 1, a low start line counts as active. When stop_pol is 1, a low stop line counts as active.
- R6: A saturation code c from 3 to 15 selects result bit c+9. When that bit becomes set, counting stops, the run ends with result equal to 2^(c+9)+2, and both sat and done are 1.
- R7: With the stop counter on, it is loaded from stop_cnt_load when a run is accepted. Stop events are rising edges of the active stop level. The first load-1 events are ignored and the run ends on event number load. While the run waits for start, state_code is 0x04. While it counts, state_code is 0x0C.
- R8: With the stop counter on, load values 0 and 1 both end the run on the first stop event.
- R9: The clear command (cmd 0), issued in idle, sets result, done and sat to 0.
- R10: The abort command (cmd 3) returns any non-idle state to idle (0x06) on the next cycle, and done stays 0.
- R11: Run commands issued while a run is in progress are ignored. The state and the final result are those of the run that is already under way.
- R12: When a run is accepted, the controller spends one cycle in state 0x07. During that cycle result is 0 and done and sat are 0.
- R13: state_code takes only these values: 0x00 (waiting for start), 0x04 (waiting for start, counter on), 0x06 (idle), 0x07 (clearing), 0x08 (counting), 0x0C (counting, counter on), 0x0E (latching result), 0x0F, 0x16, 0x1E (waiting for start to fall), 0x2E (forced stop).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd | input | 2 | 0 clear, 1 edge-started run, 2 level-started run, 3 abort |
| sat_code | input | 4 | Saturation bit select (3..15 selects bit 12..24; 0..2 select bit 24) |
| start_pol | input | 1 | 1 makes a low start level active |
| stop_pol | input | 1 | 1 makes a low stop level active |
| stop_cnt_en | input | 1 | Enables the stop-event counter |
| stop_cnt_load | input | 16 | Stop event number that ends a run |
| start_in | input | 1 | Asynchronous start line |
| stop_in | input | 1 | Asynchronous stop line |
| result | output | 25 | Edge count of the last run |
| done | output | 1 | Run complete |
| sat | output | 1 | Run ended by saturation |
| state_code | output | 6 | Encoded sequencer state |

## Verification
The properties assume that cmd_valid is a single-cycle strobe. They also assume that polarity, saturation code and stop counter settings change only while the controller is idle, so that one run always sees one saturation bit and one stop rule. The directed tests change the configuration inputs only after done is seen or after an abort. They move start_in and stop_in only on falling clock edges, and they keep each level for at least three cycles so that every stop edge gets through the synchronizer.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    typedef enum logic [5:0] {
        ST_WAIT_START     = 6'h00,
        ST_WAIT_START_CNT = 6'h04,
        ST_IDLE           = 6'h06,
        ST_CLEAR          = 6'h07,
        ST_WAIT_STOP      = 6'h08,
        ST_WAIT_STOP_CNT  = 6'h0C,
        ST_LATCH          = 6'h0E,
        ST_POWERUP        = 6'h0F,
        ST_CLEAR_WAIT     = 6'h16,
        ST_ARM_FALL       = 6'h1E,
        ST_FORCE_STOP     = 6'h2E
    } tdc_state_e;

    typedef enum logic [1:0] {
        CMD_CLEAR     = 2'd0,
        CMD_RUN_EDGE  = 2'd1,
        CMD_RUN_LEVEL = 2'd2,
        CMD_ABORT     = 2'd3
    } tdc_cmd_e;

endpackage

// File: rtl/tdc_sync2.sv
module tdc_sync2 #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/tdc_sat_sel.sv
module tdc_sat_sel #(
    parameter int RESULT_W = 25,
    parameter int CODE_W   = 4,
    parameter int MIN_CODE = 3
) (
    input  logic [CODE_W-1:0]   code,
    output logic [RESULT_W-1:0] mask
);
    // The highest code maps to the top result bit; lower codes step down.
    localparam int MAX_CODE = (1 << CODE_W) - 1;
    localparam int OFFSET   = RESULT_W - 1 - MAX_CODE;

    int unsigned bit_idx;

    always_comb begin
        if (int'(code) < MIN_CODE) bit_idx = RESULT_W - 1;  // unsupported codes fall back to the widest limit
        else                       bit_idx = int'(code) + OFFSET;
    end

    generate
        for (genvar g = 0; g < RESULT_W; g++) begin : g_mask
            assign mask[g] = (bit_idx == g);
        end
    endgenerate
endmodule

// File: rtl/tdc_stop_cnt.sv
module tdc_stop_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)     cnt_d = load_val;
        else if (dec) cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/tdc_ctrl.sv
module tdc_ctrl
    import tdc_pkg::*;
#(
    parameter int RESULT_W = 25,
    parameter int CODE_W   = 4,
    parameter int CNT_W    = 16,
    parameter int SYNC_N   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd,
    input  logic [CODE_W-1:0]   sat_code,
    input  logic                start_pol,
    input  logic                stop_pol,
    input  logic                stop_cnt_en,
    input  logic [CNT_W-1:0]    stop_cnt_load,
    input  logic                start_in,
    input  logic                stop_in,
    output logic [RESULT_W-1:0] result,
    output logic                done,
    output logic                sat,
    output logic [5:0]          state_code
);
    localparam logic [RESULT_W-1:0] EDGE_STEP = RESULT_W'(2);

    typedef struct packed {
        tdc_state_e          state;
        logic [RESULT_W-1:0] result;
        logic                done;
        logic                sat;
        logic                edge_mode;
        logic                cnt_mode;
        logic                start_prev;
        logic                stop_prev;
    } tdc_regs_t;

    tdc_regs_t r_d, r_q;

    logic [1:0]          sync_lines;
    logic [RESULT_W-1:0] sat_mask;
    logic                cnt_load, cnt_dec, cnt_last;
    logic                start_act, stop_act, stop_edge, start_fall, sat_hit;
    tdc_cmd_e            cmd_e;

    tdc_sync2 #(.WIDTH(2), .STAGES(SYNC_N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({stop_in, start_in}),
        .sync_out (sync_lines)
    );

    tdc_sat_sel #(.RESULT_W(RESULT_W), .CODE_W(CODE_W), .MIN_CODE(3)) u_sat (
        .code (sat_code),
        .mask (sat_mask)
    );

    tdc_stop_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (stop_cnt_load),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    always_comb begin
        cmd_e      = tdc_cmd_e'(cmd);
        start_act  = sync_lines[0] ^ start_pol;
        stop_act   = sync_lines[1] ^ stop_pol;
        stop_edge  = stop_act & ~r_q.stop_prev;
        start_fall = r_q.start_prev & ~start_act;
        sat_hit    = |(r_q.result & sat_mask);

        r_d            = r_q;
        r_d.start_prev = start_act;
        r_d.stop_prev  = stop_act;
        cnt_load       = 1'b0;
        cnt_dec        = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_e == CMD_CLEAR) begin
                        r_d.result = '0;
                        r_d.done   = 1'b0;
                        r_d.sat    = 1'b0;
                    end else if (cmd_e == CMD_RUN_EDGE || cmd_e == CMD_RUN_LEVEL) begin
                        r_d.state     = ST_CLEAR;
                        r_d.result    = '0;
                        r_d.done      = 1'b0;
                        r_d.sat       = 1'b0;
                        r_d.edge_mode = (cmd_e == CMD_RUN_EDGE);
                        r_d.cnt_mode  = stop_cnt_en;
                        cnt_load      = 1'b1;
                    end
                end
            end
            ST_CLEAR: begin
                if (r_q.edge_mode)     r_d.state = ST_ARM_FALL;
                else if (r_q.cnt_mode) r_d.state = ST_WAIT_START_CNT;
                else                   r_d.state = ST_WAIT_START;
            end
            ST_ARM_FALL: begin
                if (start_fall) r_d.state = r_q.cnt_mode ? ST_WAIT_START_CNT : ST_WAIT_START;
            end
            ST_WAIT_START, ST_WAIT_START_CNT: begin
                if (start_act) begin
                    r_d.state  = r_q.cnt_mode ? ST_WAIT_STOP_CNT : ST_WAIT_STOP;
                    r_d.result = r_q.result + EDGE_STEP;
                end
            end
            ST_WAIT_STOP: begin
                if (sat_hit) begin
                    r_d.state = ST_FORCE_STOP;
                    r_d.sat   = 1'b1;
                end else if (stop_act) begin
                    r_d.state = ST_LATCH;
                end else begin
                    r_d.result = r_q.result + EDGE_STEP;
                end
            end
            ST_WAIT_STOP_CNT: begin
                if (sat_hit) begin
                    r_d.state = ST_FORCE_STOP;
                    r_d.sat   = 1'b1;
                end else if (stop_edge && cnt_last) begin
                    r_d.state = ST_LATCH;
                end else begin
                    cnt_dec    = stop_edge;
                    r_d.result = r_q.result + EDGE_STEP;
                end
            end
            ST_FORCE_STOP: begin
                r_d.result = r_q.result + EDGE_STEP;  // one more cycle passes while stopping
                r_d.state  = ST_LATCH;
            end
            ST_LATCH: begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (cmd_valid && cmd_e == CMD_ABORT && r_q.state != ST_IDLE) r_d.state = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.state  <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign result     = r_q.result;
    assign done       = r_q.done;
    assign sat        = r_q.sat;
    assign state_code = r_q.state;
endmodule

// File: rtl/tdc_ctrl_chk.sv
module tdc_ctrl_chk #(
    parameter int RESULT_W = 25
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic [1:0]          cmd,
    input logic [RESULT_W-1:0] result,
    input logic                done,
    input logic                sat,
    input logic [5:0]          state_code
);
    logic counting;
    assign counting = (state_code == 6'h08) || (state_code == 6'h0C);

    AST_RESULT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !result[0]) else $error("odd result");  // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && $past(counting)) |-> (result == $past(result) + RESULT_W'(2))) else $error("count step");  // R2
    AST_SAT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 6'h06 && sat) |-> done) else $error("sat without done");  // R6
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == 2'd3) |=> (state_code == 6'h06)) else $error("abort");  // R10
    AST_BUSY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code != 6'h06 && cmd_valid && (cmd == 2'd1 || cmd == 2'd2)) |=> (state_code != 6'h07)) else $error("run while busy");  // R11
    AST_CLEAR_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 6'h07) |-> (result == '0 && !done && !sat)) else $error("clear state");  // R12
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code inside {6'h00, 6'h04, 6'h06, 6'h07, 6'h08, 6'h0C, 6'h0E, 6'h0F, 6'h16, 6'h1E, 6'h2E})) else $error("state code");  // R13
endmodule

bind tdc_ctrl tdc_ctrl_chk #(.RESULT_W(RESULT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd        (cmd),
    .result     (result),
    .done       (done),
    .sat        (sat),
    .state_code (state_code)
);

// File: tb/tdc_ctrl_test.sv
`timescale 1ns/1ps
module tdc_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic [3:0]  sat_code = 4'hF;
    logic        start_pol = 1'b0;
    logic        stop_pol = 1'b0;
    logic        stop_cnt_en = 1'b0;
    logic [15:0] stop_cnt_load = 16'd0;
    logic        start_in = 1'b0;
    logic        stop_in = 1'b0;
    logic [24:0] result;
    logic        done;
    logic        sat;
    logic [5:0]  state_code;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tdc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .sat_code(sat_code), .start_pol(start_pol), .stop_pol(stop_pol),
        .stop_cnt_en(stop_cnt_en), .stop_cnt_load(stop_cnt_load),
        .start_in(start_in), .stop_in(stop_in), .result(result),
        .done(done), .sat(sat), .state_code(state_code)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic do_cmd(input logic [1:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && !done; i++) @(negedge clk);
        chk_eq("R2 done after run", int'(done), 1);
        chk_eq("R2 idle after run", int'(state_code), 6'h06);
    endtask

    task automatic idle_lines(input logic s, input logic p);
        @(negedge clk);
        start_in = s;
        stop_in = p;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        chk_eq("R1 state", int'(state_code), 6'h06);
        chk_eq("R1 result", int'(result), 0);
        chk_eq("R1 done", int'(done), 0);
        chk_eq("R1 sat", int'(sat), 0);
    endtask

    task automatic t_async(input int k);
        idle_lines(1'b0, 1'b0);
        do_cmd(2'd2);
        chk_eq("R13 clearing code", int'(state_code), 6'h07);
        repeat (3) @(negedge clk);
        chk_eq("R13 wait start code", int'(state_code), 6'h00);
        start_in = 1'b1;
        repeat (k) @(negedge clk);
        chk_eq("R13 counting code", int'(state_code), 6'h08);
        stop_in = 1'b1;
        wait_done(100);
        chk_eq("R2 result", int'(result), 2 * k);
    endtask

    task automatic t_preactive;
        idle_lines(1'b1, 1'b0);
        do_cmd(2'd2);
        repeat (8) @(negedge clk);
        stop_in = 1'b1;
        wait_done(100);
        chk_eq("R3 result with start already active", int'(result), 18);
    endtask

    task automatic t_sync;
        idle_lines(1'b1, 1'b0);
        do_cmd(2'd1);
        repeat (4) @(negedge clk);
        chk_eq("R4 armed waiting for fall", int'(state_code), 6'h1E);
        chk_eq("R4 no count before fall", int'(result), 0);
        start_in = 1'b0;
        repeat (4) @(negedge clk);
        chk_eq("R4 waiting for rise", int'(state_code), 6'h00);
        start_in = 1'b1;
        repeat (6) @(negedge clk);
        stop_in = 1'b1;
        wait_done(100);
        chk_eq("R4 result from rise", int'(result), 12);
    endtask

    task automatic t_polarity;
        @(negedge clk);
        start_pol = 1'b1;
        stop_pol = 1'b1;
        idle_lines(1'b1, 1'b1);
        do_cmd(2'd2);
        repeat (4) @(negedge clk);
        chk_eq("R5 high start inactive", int'(state_code), 6'h00);
        start_in = 1'b0;
        repeat (7) @(negedge clk);
        stop_in = 1'b0;
        wait_done(100);
        chk_eq("R5 low-active result", int'(result), 14);
        start_pol = 1'b0;
        stop_pol = 1'b0;
    endtask

    task automatic t_saturate(input int code);
        int bitpos;
        bitpos = code + 9;
        @(negedge clk);
        sat_code = 4'(code);
        idle_lines(1'b0, 1'b0);
        do_cmd(2'd2);
        repeat (3) @(negedge clk);
        start_in = 1'b1;
        wait_done((1 << bitpos) / 2 + 50);
        chk_eq("R6 saturated result", int'(result), (1 << bitpos) + 2);
        chk_eq("R6 sat flag", int'(sat), 1);
        start_in = 1'b0;
    endtask

    task automatic t_clear;
        do_cmd(2'd0);
        chk_eq("R9 result cleared", int'(result), 0);
        chk_eq("R9 done cleared", int'(done), 0);
        chk_eq("R9 sat cleared", int'(sat), 0);
    endtask

    task automatic t_rerun;
        idle_lines(1'b0, 1'b0);
        do_cmd(2'd2);
        chk_eq("R12 clearing state", int'(state_code), 6'h07);
        chk_eq("R12 result cleared", int'(result), 0);
        chk_eq("R12 done cleared", int'(done), 0);
        chk_eq("R12 sat cleared", int'(sat), 0);
        do_cmd(2'd3);
        chk_eq("R10 abort to idle", int'(state_code), 6'h06);
    endtask

    task automatic t_stopcnt;
        @(negedge clk);
        stop_cnt_en = 1'b1;
        stop_cnt_load = 16'd3;
        idle_lines(1'b0, 1'b0);
        do_cmd(2'd2);
        repeat (3) @(negedge clk);
        chk_eq("R7 wait start counter code", int'(state_code), 6'h04);
        start_in = 1'b1;
        repeat (5) @(negedge clk);
        stop_in = 1'b1;
        repeat (3) @(negedge clk);
        stop_in = 1'b0;
        repeat (3) @(negedge clk);
        stop_in = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq("R7 still counting after two events", int'(state_code), 6'h0C);
        stop_in = 1'b0;
        repeat (3) @(negedge clk);
        stop_in = 1'b1;
        wait_done(100);
        chk_eq("R7 stop on third event", int'(result), 34);
    endtask

    task automatic t_stopcnt_first(input int load);
        @(negedge clk);
        stop_cnt_en = 1'b1;
        stop_cnt_load = 16'(load);
        idle_lines(1'b0, 1'b0);
        do_cmd(2'd2);
        repeat (3) @(negedge clk);
        start_in = 1'b1;
        repeat (5) @(negedge clk);
        stop_in = 1'b1;
        wait_done(100);
        chk_eq($sformatf("R8 load %0d stops on first event", load), int'(result), 10);
        stop_cnt_en = 1'b0;
    endtask

    task automatic t_abort;
        idle_lines(1'b0, 1'b0);
        do_cmd(2'd2);
        repeat (3) @(negedge clk);
        start_in = 1'b1;
        repeat (10) @(negedge clk);
        do_cmd(2'd3);
        chk_eq("R10 abort from counting", int'(state_code), 6'h06);
        chk_eq("R10 done stays low", int'(done), 0);
        idle_lines(1'b0, 1'b0);
        do_cmd(2'd1);
        repeat (3) @(negedge clk);
        chk_eq("R4 armed with low start", int'(state_code), 6'h1E);
        do_cmd(2'd3);
        chk_eq("R10 abort from armed", int'(state_code), 6'h06);
    endtask

    task automatic t_busy_run;
        idle_lines(1'b0, 1'b0);
        do_cmd(2'd2);
        repeat (3) @(negedge clk);
        start_in = 1'b1;
        repeat (3) @(negedge clk);
        do_cmd(2'd1);
        chk_eq("R11 run ignored while counting", int'(state_code), 6'h08);
        repeat (4) @(negedge clk);
        stop_in = 1'b1;
        wait_done(100);
        chk_eq("R11 result undisturbed", int'(result), 18);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_async(5);
        t_async(13);
        t_preactive();
        t_sync();
        t_polarity();
        t_saturate(3);
        t_clear();
        t_saturate(4);
        t_rerun();
        t_stopcnt();
        t_stopcnt_first(0);
        t_stopcnt_first(1);
        t_abort();
        t_busy_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule